// File: doc/BRIEF.md
# Multiplierless Transposed-Form FIR Filter

This block is a fixed-coefficient FIR filter with eight taps. Each clock it can take one signed sample. The sample goes to a single constant-multiplier network, and that network makes every coefficient product from shifts and additions only. The small terms 3x and 5x are built once and then reused to form 29x and 43x. The products go into a transposed chain of adder-plus-register stages. Tap 0 of that chain is also the registered output, so a result appears one clock after each accepted sample.

The coefficient set is symmetric: b0..b7 = 3, 5, 29, 43, 43, 29, 5, 3. It is fixed when the design is elaborated. The output is wide enough to hold the exact convolution of full-scale inputs, so the block has no rounding and no saturation. A cycle with the valid strobe low is a bubble. It leaves the filter history and the output word untouched.

Top module: `fir_mcm_transposed`

## Requirements
- R1: Each output equals y(n) = sum over k=0..7 of b_k·x(n-k), with b = {3, 5, 29, 43, 43, 29, 5, 3}. Here x(n) is the newest accepted sample and x(n-k) is the sample accepted k acceptances earlier. Samples accepted before the most recent reset count as zero.
- R2: When in_valid is high at a rising clock edge, out_valid is high after that edge and out_sample shows the result that includes that sample. The latency is exactly one clock.
- R3: When in_valid is low at a rising clock edge, out_valid is low after that edge, out_sample keeps its previous value, and the filter history is unchanged.
- R4: While rst is high at a clock edge (synchronous, active high), out_valid goes low, out_sample goes to zero and all history registers clear. An impulse applied after reset shows no trace of earlier samples.
- R5: out_sample is DATA_W+8 bits wide and never overflows. Full-scale inputs of -2^(DATA_W-1) on every tap give -160·2^(DATA_W-1) exactly, and inputs of 2^(DATA_W-1)-1 on every tap give 160·(2^(DATA_W-1)-1) exactly.
- R6: The shared shift-add network gives exactly 3x, 5x, 29x and 43x of the current input. It forms 29x as 8·3x + 5x and 43x as 8·5x + 3x.
- R7: in_sample and out_sample are signed two's complement. A negative impulse gives the negated coefficient sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Output result strobe |
| out_sample | output | DATA_W+8 | Signed full-precision filter output |

## Verification
A unit impulse, followed by zeros, reads the coefficient sequence out of the chain in order. This separates a wrong product, a swapped tap or a missing delay stage. A negative impulse separates arithmetic shifts from logical shifts. Runs of the extreme positive and negative values expose any width that is too narrow. Long random streams with bubbles at random places are compared with a convolution model on every clock. These streams separate a correct hold on idle cycles from a chain that shifts anyway, and a mid-stream reset followed by an impulse shows whether the history really clears.

// File: rtl/fir_mcm_pkg.sv
package fir_mcm_pkg;

  // Products available from the shared shift-add network
  typedef enum logic [1:0] {
    PROD_X3  = 2'd0,
    PROD_X5  = 2'd1,
    PROD_X29 = 2'd2,
    PROD_X43 = 2'd3
  } prod_sel_e;

  localparam int NUM_PROD   = 4;
  localparam int NUM_TAPS   = 8;
  localparam int PROD_GROW  = 6;  // largest constant 43 < 2**6

  // Product used by tap k (tap 0 multiplies the newest sample)
  function automatic prod_sel_e tap_sel(input int k);
    case (k)
      0, 7:    return PROD_X3;
      1, 6:    return PROD_X5;
      2, 5:    return PROD_X29;
      default: return PROD_X43;
    endcase
  endfunction

  function automatic int prod_value(input prod_sel_e s);
    case (s)
      PROD_X3:  return 3;
      PROD_X5:  return 5;
      PROD_X29: return 29;
      default:  return 43;
    endcase
  endfunction

  function automatic int coef_abs_sum();
    int acc;
    acc = 0;
    for (int k = 0; k < NUM_TAPS; k++) acc += prod_value(tap_sel(k));
    return acc;
  endfunction

endpackage

// File: rtl/fir_mcm_shift_add.sv
module fir_mcm_shift_add
  import fir_mcm_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int PROD_W = DATA_W + PROD_GROW
) (
  input  logic [DATA_W-1:0]                x_in,
  output logic [NUM_PROD-1:0][PROD_W-1:0]  prod_bus
);

  logic signed [PROD_W-1:0] x_ext;
  logic signed [PROD_W-1:0] t3;
  logic signed [PROD_W-1:0] t5;
  logic signed [PROD_W-1:0] t29;
  logic signed [PROD_W-1:0] t43;

  assign x_ext = {{(PROD_W-DATA_W){x_in[DATA_W-1]}}, x_in};

  // shared first-level terms
  assign t3  = x_ext + (x_ext <<< 1);
  assign t5  = x_ext + (x_ext <<< 2);
  // second level reuses both shared terms
  assign t29 = (t3 <<< 3) + t5;
  assign t43 = (t5 <<< 3) + t3;

  always_comb begin
    prod_bus           = '0;
    prod_bus[PROD_X3]  = t3;
    prod_bus[PROD_X5]  = t5;
    prod_bus[PROD_X29] = t29;
    prod_bus[PROD_X43] = t43;
  end

endmodule

// File: rtl/fir_tap_stage.sv
module fir_tap_stage #(
  parameter int PROD_W = 18,
  parameter int ACC_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PROD_W-1:0] prod,
  input  logic [ACC_W-1:0]  chain_in,
  output logic [ACC_W-1:0]  acc_q
);

  logic [ACC_W-1:0] prod_ext;

  assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= prod_ext + chain_in;
  end

endmodule

// File: rtl/fir_mcm_transposed.sv
module fir_mcm_transposed
  import fir_mcm_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int OUT_W  = DATA_W + $clog2(coef_abs_sum() + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_sample
);

  localparam int PROD_W = DATA_W + PROD_GROW;

  logic [NUM_PROD-1:0][PROD_W-1:0] prod_bus;
  logic [NUM_TAPS-1:0][OUT_W-1:0]  acc;
  logic [NUM_TAPS-1:0][OUT_W-1:0]  chain;

  fir_mcm_shift_add #(
    .DATA_W (DATA_W),
    .PROD_W (PROD_W)
  ) u_mcm (
    .x_in     (in_sample),
    .prod_bus (prod_bus)
  );

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    if (k == NUM_TAPS - 1) begin : g_end
      assign chain[k] = '0;
    end else begin : g_mid
      assign chain[k] = acc[k+1];
    end

    fir_tap_stage #(
      .PROD_W (PROD_W),
      .ACC_W  (OUT_W)
    ) u_stage (
      .clk      (clk),
      .rst      (rst),
      .en       (in_valid),
      .prod     (prod_bus[tap_sel(k)]),
      .chain_in (chain[k]),
      .acc_q    (acc[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  assign out_sample = acc[0];

endmodule

// File: rtl/fir_mcm_checker.sv
module fir_mcm_checker
  import fir_mcm_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int OUT_W  = 20,
  parameter int PROD_W = 18
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            in_valid,
  input logic [DATA_W-1:0]               in_sample,
  input logic                            out_valid,
  input logic [OUT_W-1:0]                out_sample,
  input logic [NUM_PROD-1:0][PROD_W-1:0] prod_bus
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R3
  bubble_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_sample)));

  // R4
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sample == '0));

  // R6
  prod29_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> longint'($signed(prod_bus[PROD_X29])) == longint'($signed(in_sample)) * 29);

  // R6
  prod43_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> longint'($signed(prod_bus[PROD_X43])) == longint'($signed(in_sample)) * 43);

  // R6
  prod_small_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (longint'($signed(prod_bus[PROD_X3])) == longint'($signed(in_sample)) * 3 &&
                  longint'($signed(prod_bus[PROD_X5])) == longint'($signed(in_sample)) * 5));

endmodule

bind fir_mcm_transposed fir_mcm_checker #(
  .DATA_W (DATA_W),
  .OUT_W  (OUT_W),
  .PROD_W (PROD_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_sample  (in_sample),
  .out_valid  (out_valid),
  .out_sample (out_sample),
  .prod_bus   (prod_bus)
);

// File: tb/sim_fir_mcm_transposed.sv
module sim_fir_mcm_transposed;

  localparam int CLK_PERIOD = 10;
  localparam int DW   = 12;
  localparam int OW   = DW + 8;
  localparam int TAPS = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_sample = '0;
  logic          out_valid;
  logic [OW-1:0] out_sample;

  int     n_tests = 0;
  int     n_fail  = 0;
  int     coef[TAPS] = '{3, 5, 29, 43, 43, 29, 5, 3};
  int     hist[TAPS];
  longint exp_out = 0;
  logic   exp_valid = 1'b0;

  fir_mcm_transposed #(.DATA_W(DW)) u0 (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic model_clear();
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    exp_out   = 0;
    exp_valid = 1'b0;
  endtask

  task automatic check_outputs(input string tag);
    longint got;
    got = longint'($signed(out_sample));
    n_tests++;
    if (out_valid !== exp_valid) begin
      n_fail++;
      $display("FAIL %s valid: got %0b exp %0b", tag, out_valid, exp_valid);
    end
    n_tests++;
    if (got != exp_out) begin
      n_fail++;
      $display("FAIL %s data: got %0d exp %0d", tag, got, exp_out);
    end
  endtask

  // called just after a falling edge
  task automatic step(input logic v, input int x, input string tag);
    in_valid  = v;
    in_sample = DW'(x);
    if (v) begin
      for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      exp_out = 0;
      for (int k = 0; k < TAPS; k++) exp_out += longint'(coef[k]) * hist[k];
    end
    exp_valid = v;
    @(posedge clk);
    @(negedge clk);
    check_outputs(tag);
  endtask

  task automatic do_reset(input int cycles);
    rst      = 1'b1;
    in_valid = 1'b0;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
    model_clear();
    check_outputs("R4 reset");
    rst = 1'b0;
  endtask

  task automatic impulse(input int amp, input string tag);
    step(1'b1, amp, tag);
    for (int i = 0; i < TAPS + 1; i++) step(1'b1, 0, tag);
  endtask

  initial begin
    model_clear();
    @(negedge clk);
    do_reset(3);

    impulse(1, "R1 impulse");
    impulse(-1, "R7 neg impulse");

    // latency and bubbles
    step(1'b1, 100, "R2 latency");
    step(1'b0, 777, "R3 bubble");
    step(1'b0, -5, "R3 bubble");
    step(1'b1, -300, "R2 latency");
    step(1'b0, 1234, "R3 bubble");

    // full scale
    for (int i = 0; i < TAPS + 2; i++) step(1'b1, -(1 << (DW-1)), "R5 neg full scale");
    for (int i = 0; i < TAPS + 2; i++) step(1'b1, (1 << (DW-1)) - 1, "R5 pos full scale");
    for (int i = 0; i < TAPS + 2; i++)
      step(1'b1, (i % 2 == 0) ? -(1 << (DW-1)) : (1 << (DW-1)) - 1, "R7 alternating");

    // random stream with random bubbles
    for (int i = 0; i < 400; i++) begin
      logic v;
      v = ($urandom_range(0, 3) != 0);
      step(v, int'($urandom_range(0, (1 << DW) - 1)) - (1 << (DW-1)),
           v ? "R1 random" : "R3 random bubble");
    end

    // reset in the middle of a stream must wipe history
    do_reset(2);
    impulse(1, "R4 post-reset impulse");

    for (int i = 0; i < 50; i++)
      step(1'b1, int'($urandom_range(0, 63)) - 32, "R1 small random");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule